// File: doc/BRIEF.md
# Triplicated Voting Stage with Capture Scan

This block keeps three identical copies of a small registered datapath (each copy registers its input incremented by one when enabled) and feeds all three results into three separate bitwise majority voters. Both the module copies and the voters are replicated, so a fault in any one of them is outvoted by the other two and the voted outputs stay correct. The voters contain no state; only the module copies hold registers.

Because redundancy hides a single bad copy from the functional outputs, a scan chain sits around every module output and every voter output. A capture strobe loads all of these words into the chain in one clock. Shift cycles then stream the captured bits out on a single serial pin to an outside checker, which can tell which copy or voter disagrees. Each module copy has a fault-injection hook (forced low, forced high or inverted bits under a mask) so that self-checking tests can plant a disagreement and confirm that it is both masked and visible in the scan stream.

Top module: `tmr_scan_stage`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled load, all three voted outputs and the scan output are 0.
- R2: On a clock edge with `en` high each module copy registers `din + 1` (wrapping modulo 2^W); with `en` low it holds its value.
- R3: All three voted outputs equal, bit by bit, the majority of the three module copy outputs (after injection), and they change in the same cycle as the module outputs with no added register.
- R4: A fault injected into any single module copy, of any kind and any mask, leaves the three voted outputs equal to the fault-free result.
- R5: The 2-bit injection code of a copy selects 0 = no fault, 1 = masked bits forced to 0, 2 = masked bits forced to 1, 3 = masked bits inverted; copy A uses `inj_mode[1:0]` and `inj_mask[W-1:0]`, copy B bits [3:2] and [2W-1:W], copy C bits [5:4] and [3W-1:2W].
- R6: A clock edge with `capture` high loads all 6W scan cells at once from the module and voter outputs present before that edge, and `scan_out` then shows bit 0 of copy A.
- R7: The scan order is copy A, copy B, copy C, then voter A, voter B, voter C, each word least significant bit first; chain bit i appears on `scan_out` after i shift cycles following the capture.
- R8: Each edge with `shift` high and `capture` low advances the chain by one bit, filling with 0 behind, so after 6W shifts `scan_out` is 0; with both low the chain holds.
- R9: When `capture` and `shift` are high on the same edge, the capture wins and `scan_out` shows bit 0 of the new capture.
- R10: Capturing and shifting never alter the voted outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| en | input | 1 | Load enable for the module copies |
| din | input | W | Functional input data |
| capture | input | 1 | Parallel load strobe for the scan chain |
| shift | input | 1 | Serial advance enable for the scan chain |
| inj_mode | input | 6 | Fault-injection code, 2 bits per module copy |
| inj_mask | input | 3*W | Fault-injection bit mask, W bits per module copy |
| vote_a | output | W | Voter A result |
| vote_b | output | W | Voter B result |
| vote_c | output | W | Voter C result |
| scan_out | output | 1 | Serial scan data |

## Verification
The bench builds the block with its default width W = 8, which makes the chain 48 bits long, so a full capture-and-unload pass fits in about fifty cycles and many passes can be run alongside random data. With eight-bit words the increment wraps from 255 to 0 within reach of random and directed values, and every mask pattern of a single copy can be mixed with double faults that do break the vote. Each unload is compared bit by bit against a word list built from a bench model of the copies and injection codes.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;

  typedef enum logic [1:0] {
    INJ_OFF   = 2'd0,
    INJ_CLR   = 2'd1,
    INJ_SET   = 2'd2,
    INJ_INV   = 2'd3
  } inj_kind_e;

  localparam int unsigned NUM_COPIES = 3;
  localparam int unsigned WORDS_PER_CHAIN = 2 * NUM_COPIES;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/tmr_replica.sv
module tmr_replica
  import tmr_scan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  input  logic [1:0]   fault_code,
  input  logic [W-1:0] fault_mask,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] word_out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  inj_kind_e    kind;

  always_comb begin
    acc_d = acc_q;
    if (en) begin
      acc_d = din + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign kind = inj_kind_e'(fault_code);

  always_comb begin
    unique case (kind)
      INJ_CLR: word_out = acc_q & ~fault_mask;
      INJ_SET: word_out = acc_q | fault_mask;
      INJ_INV: word_out = acc_q ^ fault_mask;
      default: word_out = acc_q;
    endcase
  end

  assign raw_q = acc_q;

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] result
);

  always_comb begin
    result = (in_a & in_b) | (in_b & in_c) | (in_a & in_c);
  end

endmodule

// File: rtl/tmr_scan_chain.sv
module tmr_scan_chain #(
  parameter int unsigned LEN = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           shift,
  input  logic [LEN-1:0] load_vec,
  output logic           sout
);

  logic [LEN-1:0] cells_q;
  logic [LEN-1:0] cells_d;

  always_comb begin
    cells_d = cells_q;
    if (capture) begin
      cells_d = load_vec;
    end else if (shift) begin
      cells_d = {1'b0, cells_q[LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
    end else begin
      cells_q <= cells_d;
    end
  end

  assign sout = cells_q[0];

endmodule

// File: rtl/tmr_scan_stage.sv
module tmr_scan_stage
  import tmr_scan_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [W-1:0]               din,
  input  logic                       capture,
  input  logic                       shift,
  input  logic [2*NUM_COPIES-1:0]    inj_mode,
  input  logic [NUM_COPIES*W-1:0]    inj_mask,
  output logic [W-1:0]               vote_a,
  output logic [W-1:0]               vote_b,
  output logic [W-1:0]               vote_c,
  output logic                       scan_out
);

  localparam int unsigned CHAIN_LEN = WORDS_PER_CHAIN * W;

  logic                       rst_int_n;
  logic [NUM_COPIES*W-1:0]    raw_q;
  logic [NUM_COPIES*W-1:0]    mod_out;
  logic [NUM_COPIES*W-1:0]    vote_bus;
  logic [CHAIN_LEN-1:0]       capture_vec;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar r = 0; r < NUM_COPIES; r++) begin : g_copy
    tmr_replica #(.W(W)) u_rep (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .en         (en),
      .din        (din),
      .fault_code (inj_mode[2*r +: 2]),
      .fault_mask (inj_mask[r*W +: W]),
      .raw_q      (raw_q[r*W +: W]),
      .word_out   (mod_out[r*W +: W])
    );

    tmr_voter #(.W(W)) u_vote (
      .in_a   (mod_out[0 +: W]),
      .in_b   (mod_out[W +: W]),
      .in_c   (mod_out[2*W +: W]),
      .result (vote_bus[r*W +: W])
    );
  end

  assign capture_vec = {vote_bus, mod_out};

  tmr_scan_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .capture  (capture),
    .shift    (shift),
    .load_vec (capture_vec),
    .sout     (scan_out)
  );

  assign vote_a = vote_bus[0 +: W];
  assign vote_b = vote_bus[W +: W];
  assign vote_c = vote_bus[2*W +: W];

endmodule

// File: rtl/tmr_scan_stage_chk.sv
module tmr_scan_stage_chk #(
  parameter int unsigned W = 8
) (
  input logic           clk,
  input logic           rst_int_n,
  input logic           en,
  input logic [W-1:0]   din,
  input logic           capture,
  input logic           shift,
  input logic [5:0]     inj_mode,
  input logic [3*W-1:0] raw_q,
  input logic [3*W-1:0] mod_out,
  input logic [W-1:0]   vote_a,
  input logic [W-1:0]   vote_b,
  input logic [W-1:0]   vote_c,
  input logic           scan_out
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [2:0] faulty;
  assign faulty = {|inj_mode[5:4], |inj_mode[3:2], |inj_mode[1:0]};

  // R3: the three separate voters agree
  a_r3_voters_agree: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vote_a == vote_b) && (vote_b == vote_c));

  // R2: enabled load of copy A
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    en |=> raw_q[W-1:0] == $past(din) + ONE);

  // R2: hold when disabled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> $stable(raw_q));

  // R2: copies track each other
  a_r2_copies_equal: assert property (@(posedge clk) disable iff (!rst_int_n)
    (raw_q[W-1:0] == raw_q[W +: W]) && (raw_q[W +: W] == raw_q[2*W +: W]));

  // R4: a single faulty copy is outvoted
  a_r4_single_masked: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($countones(faulty) <= 1) |-> vote_a == raw_q[W-1:0]);

  // R6: capture puts bit 0 of copy A on the pin
  a_r6_capture_bit0: assert property (@(posedge clk) disable iff (!rst_int_n)
    capture |=> scan_out == $past(mod_out[0]));

  // R8: idle chain holds
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!capture && !shift) |=> $stable(scan_out));

endmodule

bind tmr_scan_stage tmr_scan_stage_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .en        (en),
  .din       (din),
  .capture   (capture),
  .shift     (shift),
  .inj_mode  (inj_mode),
  .raw_q     (raw_q),
  .mod_out   (mod_out),
  .vote_a    (vote_a),
  .vote_b    (vote_b),
  .vote_c    (vote_c),
  .scan_out  (scan_out)
);

// File: tb/tmr_scan_stage_tb.sv
module tmr_scan_stage_tb_top;

  localparam int W = 8;
  localparam int LEN = 6 * W;

  logic           clk;
  logic           rst_n;
  logic           en;
  logic [W-1:0]   din;
  logic           capture;
  logic           shift;
  logic [5:0]     inj_mode;
  logic [3*W-1:0] inj_mask;
  logic [W-1:0]   vote_a, vote_b, vote_c;
  logic           scan_out;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] q_m;
  logic [LEN-1:0] exp_vec;
  bit done = 0;

  tmr_scan_stage #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .capture(capture),
    .shift(shift), .inj_mode(inj_mode), .inj_mask(inj_mask),
    .vote_a(vote_a), .vote_b(vote_b), .vote_c(vote_c), .scan_out(scan_out)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] faulted(logic [W-1:0] v, logic [1:0] code, logic [W-1:0] m);
    case (code)
      2'd1: return v & ~m;
      2'd2: return v | m;
      2'd3: return v ^ m;
      default: return v;
    endcase
  endfunction

  function automatic logic [W-1:0] copy_word(int r);
    return faulted(q_m, inj_mode[2*r +: 2], inj_mask[r*W +: W]);
  endfunction

  function automatic logic [W-1:0] majority();
    logic [W-1:0] a, b, c;
    a = copy_word(0); b = copy_word(1); c = copy_word(2);
    return (a & b) | (b & c) | (a & c);
  endfunction

  function automatic logic [LEN-1:0] scan_image();
    logic [W-1:0] v;
    v = majority();
    return {v, v, v, copy_word(2), copy_word(1), copy_word(0)};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_votes(string req);
    logic [W-1:0] m;
    m = majority();
    check(req, {vote_a, vote_b, vote_c}, {m, m, m});
  endtask

  // one clock: inputs already set, model updated at the edge, check after
  task automatic tick();
    @(posedge clk);
    if (en) q_m = din + W'(1);
    #2;
  endtask

  task automatic rand_fault(bit allow_double);
    int pick;
    inj_mode = '0;
    inj_mask = {$urandom, $urandom};
    pick = int'($urandom_range(0, 9));
    if (pick < 7) inj_mode[2*(pick % 3) +: 2] = 2'($urandom);
    else if (pick == 9 && allow_double) inj_mode = 6'($urandom);
  endtask

  // capture and unload the whole chain, with optional simultaneous shift
  task automatic unload(bit with_shift, bit random_data);
    @(negedge clk);
    capture = 1; shift = with_shift;
    exp_vec = scan_image();
    tick();
    check(with_shift ? "R9 capture over shift" : "R6 capture bit0", scan_out, exp_vec[0]);
    for (int j = 1; j <= LEN; j++) begin
      @(negedge clk);
      capture = 0; shift = 1;
      if (random_data) begin en = 1'($urandom); din = W'($urandom); end
      tick();
      check(j == LEN ? "R8 zero fill" : "R7 scan order", scan_out,
            j < LEN ? exp_vec[j] : 1'b0);
      check_votes("R10 votes during shift");
    end
    @(negedge clk);
    shift = 0; en = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; en = 0; din = '0; capture = 0; shift = 0;
    inj_mode = '0; inj_mask = '0; q_m = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset votes", {vote_a, vote_b, vote_c}, '0);
    check("R1 reset scan", scan_out, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (3) tick();
    check("R1 after release", {vote_a, vote_b, vote_c, scan_out}, '0);

    // R2 wrap and hold
    @(negedge clk); en = 1; din = 8'hFF; tick();
    check("R2 wrap", vote_a, 8'h00);
    @(negedge clk); din = 8'h41; tick();
    check("R2 load", vote_b, 8'h42);
    @(negedge clk); en = 0; din = 8'h10; tick();
    check("R2 hold", vote_c, 8'h42);

    // R5 directed encodings on copy B, seen in scan; R4 votes unchanged
    for (int code = 1; code < 4; code++) begin
      @(negedge clk);
      inj_mode = 6'(code << 2); inj_mask = {8'h00, 8'h0F, 8'h00};
      #1;
      check_votes("R4 single fault masked");
      check("R4 vote value", vote_a, 8'h42);
      unload(0, 0);
    end

    // R8 idle hold after a capture
    @(negedge clk); capture = 1; exp_vec = scan_image(); tick();
    @(negedge clk); capture = 0;
    for (int k = 0; k < 4; k++) tick();
    check("R8 idle hold", scan_out, exp_vec[0]);

    // R9 capture with shift on same edge
    @(negedge clk); inj_mode = 6'b11_00_00; inj_mask = {8'hA5, 16'h0};
    unload(1, 0);

    // R3 double fault breaks the vote predictably
    @(negedge clk); inj_mode = 6'b00_10_10; inj_mask = {8'h00, 8'h81, 8'h81}; #1;
    check("R3 double fault majority", vote_a, 8'h42 | 8'h81);

    // random traffic with periodic unloads
    for (int it = 0; it < 300; it++) begin
      @(negedge clk);
      en = 1'($urandom); din = W'($urandom);
      rand_fault(1);
      capture = 0; shift = 0;
      tick();
      check_votes("R3 random majority");
      if (it % 40 == 39) begin
        rand_fault(0);
        unload(it % 80 == 79, 1);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule